// File: doc/BRIEF.md
# Receive Tuning Window Search Engine

This block finds a good receive sampling point for a high-speed card link without software taking part. After a start pulse it steps a 6-bit delay tap upward from zero through a limited range. For each tap it loads the PHY through a control word. The update bit in that word is raised and held until the PHY reports the update complete, and this load is done twice. It then asks an external checker to run one tuning-block transfer, and the checker answers with pass or fail.

While it sweeps, the engine keeps the length of the current run of consecutive passing taps, the length of the best run so far, and the tap where the best run ended. After the last tap it loads the centre of the best run with the same double update and reports done. If no tap passed, it reports an error instead and loads nothing. A PHY that never completes an update costs one tap, which is counted as a fail. If this happens during the final load, the engine reports an error.

Top module: `rx_tap_tuner`

## Requirements
- R1: After start the engine visits taps 0, 1, ... up to TAP_LAST (39 by default) in ascending order and never beyond. The tap is driven on ctrl_word[13:8].
- R2: For each tap the update bit ctrl_word[15] rises exactly twice with the tap stable. Each time it stays high until upd_done and then drops. All ctrl_word bits other than 15 and 13:8 are zero.
- R3: If upd_done does not arrive within UPD_TIMEOUT cycles of the update bit rising, the bit drops and the tap counts as a fail, with no second update and no check. During the final load this ends the run with err.
- R4: The best run is the longest run of consecutive passing taps. A later run replaces it only if it is strictly longer, so on a tie the lowest run is kept.
- R5: The final tap equals the last tap of the best run minus half its length, rounded down. It is loaded with two updates, and done rises after the second update completes.
- R6: If no tap passed, err is raised after the sweep and the update bit is not raised again.
- R7: chk_req is a one-cycle pulse, issued once per tap only after that tap's second update has completed. The result is taken from chk_pass when chk_rsp is high.
- R8: busy is high from the cycle after an accepted start until done or err. done and err hold until the next start. A start while busy is ignored.
- R9: After reset, ctrl_word, chk_req, busy, done and err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep when idle |
| upd_done | input | 1 | PHY pulse: the raised update has completed |
| chk_rsp | input | 1 | Checker response strobe |
| chk_pass | input | 1 | Checker result, valid with chk_rsp |
| ctrl_word | output | 16 | PHY control word: update bit 15, tap 13:8 |
| chk_req | output | 1 | One-cycle request for one tuning-block check |
| busy | output | 1 | Sweep or final load in progress |
| done | output | 1 | Final tap loaded |
| err | output | 1 | No passing tap, or final load timed out |

## Verification
The results come after delays that depend on how the PHY and checker models respond, so the bench does not compare against fixed cycle numbers. It follows events instead. Each rise of the update bit is counted against the tap shown in the same cycle. Each chk_req is checked against the previous request for order and range. busy is sampled on the negative edge one cycle after start. The final tap, done and err are read on the negative edge after either flag rises, and the update-rise totals are compared with counts worked out from the pass pattern and the set of stuck taps.

// File: rtl/rx_tap_tuner.sv
module rx_tap_tuner #(
  parameter int TAP_W       = 6,
  parameter int TAP_LAST    = 39,
  parameter int UPD_TIMEOUT = 16,
  parameter int UPD_REPEAT  = 2,
  parameter int CTRL_W      = 16,
  parameter int TAP_LSB     = 8,
  parameter int UPD_BIT     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              upd_done,
  input  logic              chk_rsp,
  input  logic              chk_pass,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              chk_req,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int TW = $clog2(UPD_TIMEOUT + 1);
  localparam int RW = $clog2(UPD_REPEAT + 1);
  localparam int LW = $clog2(TAP_LAST + 2);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_UPD, S_GAP, S_CHK} st_t;

  st_t             st;
  logic [TAP_W-1:0] tap, last_end, end_n, centre;
  logic            upd, final_ph;
  logic [RW-1:0]   rep;
  logic [TW-1:0]   tmo;
  logic [LW-1:0]   cur, best, cur_n, best_n;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[UPD_BIT] = upd;
    ctrl_word[TAP_LSB +: TAP_W] = tap;
  end

  wire upd_tmo    = (st == S_UPD) && !upd_done && (tmo == TW'(UPD_TIMEOUT - 1));
  wire sweep_step = !final_ph && (((st == S_CHK) && chk_rsp) || upd_tmo);
  wire step_pass  = (st == S_CHK) && chk_pass;
  wire grow       = step_pass && (cur_n > best);

  assign cur_n  = step_pass ? cur + LW'(1) : '0;
  assign best_n = grow ? cur_n : best;
  assign end_n  = grow ? tap : last_end;
  assign centre = end_n - TAP_W'(best_n >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tap <= '0; upd <= 1'b0; final_ph <= 1'b0;
      rep <= '0; tmo <= '0; cur <= '0; best <= '0; last_end <= '0;
      chk_req <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      chk_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tap <= '0; final_ph <= 1'b0; rep <= '0;
          cur <= '0; best <= '0; last_end <= '0;
          busy <= 1'b1; done <= 1'b0; err <= 1'b0;
          st <= S_ARM;
        end
        S_ARM: begin
          upd <= 1'b1; tmo <= '0; st <= S_UPD;
        end
        S_UPD: begin
          if (upd_done) begin
            upd <= 1'b0; st <= S_GAP;
          end else if (upd_tmo) begin
            upd <= 1'b0;
            if (final_ph) begin
              err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
            end
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        S_GAP: begin
          if (rep == RW'(UPD_REPEAT - 1)) begin
            if (final_ph) begin
              done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
            end else begin
              chk_req <= 1'b1; st <= S_CHK;
            end
          end else begin
            rep <= rep + RW'(1); st <= S_ARM;
          end
        end
        default: ;
      endcase

      if (sweep_step) begin
        cur <= cur_n; best <= best_n; last_end <= end_n;
        rep <= '0; upd <= 1'b0;
        if (tap == TAP_W'(TAP_LAST)) begin
          if (best_n == '0) begin
            err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else begin
            tap <= centre; final_ph <= 1'b1; st <= S_ARM;
          end
        end else begin
          tap <= tap + TAP_W'(1); st <= S_ARM;
        end
      end
    end
  end

  assert_tap_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_ph) |-> (tap <= TAP_W'(TAP_LAST)));
  assert_upd_tap_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && $past(upd)) |-> $stable(tap));
  assert_tmo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) |-> (tmo < TW'(UPD_TIMEOUT)));
  assert_best_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best >= $past(best)));
  assert_err_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !final_ph) |-> !upd);
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> !chk_req);
  assert_req_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !upd);
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (done || err)) && !(done && err));
endmodule

// File: tb/tb_rx_tap_tuner.sv
module tb_rx_tap_tuner;
  localparam int NT = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic upd_done = 1'b0, chk_rsp = 1'b0, chk_pass = 1'b0;
  logic [15:0] ctrl_word;
  logic chk_req, busy, done, err;

  rx_tap_tuner dut (.clk(clk), .rst_n(rst_n), .start(start), .upd_done(upd_done),
    .chk_rsp(chk_rsp), .chk_pass(chk_pass), .ctrl_word(ctrl_word),
    .chk_req(chk_req), .busy(busy), .done(done), .err(err));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [NT-1:0] pat, stuck;
  bit kill_final;
  int resolved, rises, last_rise_tap, nreq, last_req_tap, order_bad, extra_bad;
  int phy_cnt, rsp_cnt, rsp_tap;
  logic prev_b15;

  wire [5:0] tap_now = ctrl_word[13:8];
  wire sweep_over = (resolved >= NT);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    upd_done <= 1'b0;
    chk_rsp  <= 1'b0;
    if (phy_cnt != 0) begin
      phy_cnt <= phy_cnt - 1;
      if (phy_cnt == 1) upd_done <= 1'b1;
    end
    if (ctrl_word[15] && !prev_b15) begin
      rises++;
      last_rise_tap <= int'(tap_now);
      if (sweep_over ? kill_final : stuck[tap_now]) begin
        if (!sweep_over) resolved++;
      end else phy_cnt <= 3;
    end
    prev_b15 <= ctrl_word[15];
    if ((ctrl_word & 16'h3F00) != ctrl_word && ctrl_word[15] == 1'b0) extra_bad++;
    if ((ctrl_word & 16'hBF00) != ctrl_word) extra_bad++;
    if (rsp_cnt != 0) begin
      rsp_cnt <= rsp_cnt - 1;
      if (rsp_cnt == 1) begin
        chk_rsp <= 1'b1;
        chk_pass <= pat[rsp_tap];
        resolved++;
      end
    end
    if (chk_req) begin
      nreq++;
      if (int'(tap_now) <= last_req_tap || int'(tap_now) >= NT) order_bad++;
      last_req_tap <= int'(tap_now);
      rsp_cnt <= 2;
      rsp_tap <= int'(tap_now);
    end
  end

  task automatic run_case(input logic [NT-1:0] p, input logic [NT-1:0] s,
                          input bit kf, input bit mid_start, input string name);
    int cur = 0, best = 0, bend = 0, exp_tap, exp_rises = 0, exp_req = 0;
    bit exp_err;
    int w;
    for (int i = 0; i < NT; i++) begin
      if (p[i] && !s[i]) begin
        cur++;
        if (cur > best) begin best = cur; bend = i; end
      end else cur = 0;
      exp_rises += s[i] ? 1 : 2;
      if (!s[i]) exp_req++;
    end
    exp_tap = bend - best / 2;
    exp_err = (best == 0) || kf;
    if (best != 0) exp_rises += kf ? 1 : 2;
    @(negedge clk);
    pat = p; stuck = s; kill_final = kf;
    resolved = 0; rises = 0; nreq = 0; last_req_tap = -1; order_bad = 0; extra_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy && !done && !err, {"R8 busy after start ", name}, busy, 1);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!(done || err) && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 20000, {"R8 completion ", name}, w, 0);
    chk(err == exp_err && done == !exp_err, {"R6 outcome ", name}, err, exp_err);
    chk(!busy, {"R8 busy cleared ", name}, busy, 0);
    chk(nreq == exp_req, {"R7 check count ", name}, nreq, exp_req);
    chk(order_bad == 0, {"R1 ascending taps ", name}, order_bad, 0);
    chk(rises == exp_rises, {"R2 R3 update count ", name}, rises, exp_rises);
    chk(extra_bad == 0, {"R2 unused bits zero ", name}, extra_bad, 0);
    if (!exp_err) begin
      chk(int'(tap_now) == exp_tap, {"R5 R4 final tap ", name}, tap_now, exp_tap);
      chk(last_rise_tap == exp_tap, {"R5 loaded tap ", name}, last_rise_tap, exp_tap);
    end
    chk(!ctrl_word[15], {"R6 update bit idle ", name}, ctrl_word[15], 0);
    repeat (3) @(negedge clk);
    chk((done || err) && !busy, {"R8 flags held ", name}, done | err, 1);
  endtask

  initial begin
    phy_cnt = 0; rsp_cnt = 0; prev_b15 = 1'b0;
    pat = '0; stuck = '0; kill_final = 1'b0;
    resolved = 0; rises = 0; nreq = 0; last_req_tap = -1; order_bad = 0; extra_bad = 0;
    last_rise_tap = 0; rsp_tap = 0;
    repeat (3) @(negedge clk);
    chk(ctrl_word == 16'h0 && !chk_req && !busy && !done && !err, "R9 reset state", ctrl_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case({NT{1'b1}}, '0, 1'b0, 1'b0, "all pass");
    run_case('0, '0, 1'b0, 1'b0, "none pass");
    run_case(40'h1, '0, 1'b0, 1'b0, "tap0 only");
    run_case(40'h1 << 39, '0, 1'b0, 1'b0, "tap39 only");
    run_case((40'h7 << 5) | (40'h7 << 20), '0, 1'b0, 1'b0, "tie R4");
    run_case((40'h3 << 3) | (40'h3FF << 30), '0, 1'b0, 1'b0, "later longer");
    run_case(40'hF << 10, '0, 1'b0, 1'b0, "even length");
    run_case(40'h3FF << 10, (40'h1 << 15) | (40'h1 << 2), 1'b0, 1'b0, "stuck R3");
    run_case({NT{1'b1}}, '0, 1'b1, 1'b0, "final timeout R3");
    run_case((40'h1F << 8) | (40'h3F << 25), '0, 1'b0, 1'b1, "start while busy R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule